// File: doc/BRIEF.md
# Four-Level Backplane Bus Arbiter

This block decides which of four request levels on a shared backplane receives the bus. Each level has an active-low request input and an active-low grant output. A control input selects the ordering. In fixed ordering the highest-numbered active level wins. In rotating ordering the search starts at a pointer and wraps, so that every level is served in turn. After a master has been granted, it drives a shared active-low bus-busy line. Some masters drop busy after every transfer and must arbitrate again. Others keep busy asserted between transfers and give the bus up only when the arbiter drives its active-low bus-clear output.

The control path is a four-state machine:
- `ST_IDLE`: no grant, and the bus is not known to be owned.
- `ST_GRANT`: one grant line is driven low.
- `ST_OWNED`: the granted master holds busy.
- `ST_CLEAR`: bus clear is driven because a stronger request is waiting.

The transitions are:
- IDLE→GRANT: busy is high and at least one request is active.
- GRANT→OWNED: busy is seen low.
- OWNED→IDLE: busy is released.
- OWNED→CLEAR: a pending request beats the owner's level.
- CLEAR→IDLE: busy is released.

Every other case keeps the current state. All outputs are decoded from registered state, so each output follows its cause by one clock.

Top module: `bus_arbiter4`

## Requirements
- R1: After reset every grant output is high, the bus-clear output is high, the rotation pointer selects level 0, and the latched ordering is fixed.
- R2: At most one bit of `grant_n_o` is low at any time.
- R3: In fixed ordering (`order_rot_i` = 0) the grant goes to the active request with the highest index. `req_n_i[3]` outranks `req_n_i[0]`, and a request is active when its bit is 0.
- R4: In rotating ordering (`order_rot_i` = 1) the winner is the first active level found from the pointer upward, wrapping after level 3. A rotating grant to level L moves the pointer to (L+1) mod 4. A grant made in fixed ordering leaves the pointer unchanged.
- R5: No grant is issued while `busy_n_i` is low. When busy is high in the idle state and a request is active, the grant appears one clock later.
- R6: A grant stays low and unchanged until `busy_n_i` is seen low. It is removed on the clock after that.
- R7: After the owner releases busy, there is one idle clock with no grant. The next grant is then decided afresh from the requests present at that time.
- R8: While the bus is owned, `clear_n_o` goes low one clock after a pending request that beats the owner appears. In fixed ordering only a higher index beats the owner. In rotating ordering any other level beats it. A request at the owner's own level never does.
- R9: Once low, `clear_n_o` stays low while busy is held. It returns high on the clock after busy is released, and no grant is driven while it is low.
- R10: `order_rot_i` is sampled only in the idle state. The sampled value governs both the grant and the bus-clear decision until the bus next becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| order_rot_i | input | 1 | Ordering select: 0 fixed, 1 rotating; read only while idle |
| req_n_i | input | 4 | Active-low bus requests, one per level |
| busy_n_i | input | 1 | Active-low shared bus-busy line driven by the owner |
| grant_n_o | output | 4 | Active-low bus grants, one per level |
| clear_n_o | output | 1 | Active-low bus-clear request to the current owner |

## Verification
The hardest situation to reach is a change of `order_rot_i` while a master keeps the bus. The latched ordering must then hold back bus clear for a lower level that the new ordering would favour. The bench reaches this as follows. It grants level 2 in fixed ordering and holds busy. It flips the ordering input and raises a level-0 request, then checks that clear stays high. The following rotating grant then shows that the pointer was left at 0 by the fixed-ordering grant.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Control states of the arbiter
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_OWNED = 2'd2,
        ST_CLEAR = 2'd3
    } arb_state_e;

    // Ordering between competing request levels
    typedef enum logic {
        ORD_FIXED  = 1'b0,
        ORD_ROTATE = 1'b1
    } arb_order_e;

endpackage

// File: rtl/arb_pick.sv
// Chooses the winning level among active requests.
module arb_pick
    import arb_pkg::*;
#(
    parameter int NLVL  = 4,
    parameter int LVL_W = 2
) (
    input  logic [NLVL-1:0]  req,
    input  arb_order_e       order,
    input  logic [LVL_W-1:0] ptr,
    output logic             win_vld,
    output logic [LVL_W-1:0] win_lvl
);

    always_comb begin
        int idx;
        win_vld = 1'b0;
        win_lvl = '0;
        idx     = 0;
        if (order == ORD_FIXED) begin
            // ascending scan: the last hit is the highest index
            for (int i = 0; i < NLVL; i++) begin
                if (req[i]) begin
                    win_vld = 1'b1;
                    win_lvl = LVL_W'(i);
                end
            end
        end else begin
            // descending distance from the pointer: the last hit is the nearest
            for (int k = NLVL-1; k >= 0; k--) begin
                idx = (int'(ptr) + k) % NLVL;
                if (req[LVL_W'(idx)]) begin
                    win_vld = 1'b1;
                    win_lvl = LVL_W'(idx);
                end
            end
        end
    end

    always_comb begin
        if (win_vld) begin
            assert (req[win_lvl])
                else $error("assert_winner_requests_R3: winner level not requesting");
        end
    end

endmodule

// File: rtl/arb_clear.sv
// Decides whether a pending request outranks the current owner.
module arb_clear
    import arb_pkg::*;
#(
    parameter int NLVL  = 4,
    parameter int LVL_W = 2
) (
    input  logic [NLVL-1:0]  req,
    input  arb_order_e       order,
    input  logic [LVL_W-1:0] owner,
    output logic             beats
);

    always_comb begin
        beats = 1'b0;
        for (int i = 0; i < NLVL; i++) begin
            if (req[i] && (i != int'(owner))) begin
                if (order == ORD_ROTATE || i > int'(owner)) begin
                    beats = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bus_arbiter4.sv
module bus_arbiter4
    import arb_pkg::*;
#(
    parameter int NLVL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            order_rot_i,
    input  logic [NLVL-1:0] req_n_i,
    input  logic            busy_n_i,
    output logic [NLVL-1:0] grant_n_o,
    output logic            clear_n_o
);

    localparam int LVL_W = (NLVL > 1) ? $clog2(NLVL) : 1;

    arb_state_e       state_q, state_d;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] ptr_q;
    arb_order_e       order_q;

    logic [NLVL-1:0]  req;
    logic             busy;
    arb_order_e       order_live;
    logic             win_vld;
    logic [LVL_W-1:0] win_lvl;
    logic             beats;

    assign req        = ~req_n_i;
    assign busy       = ~busy_n_i;
    assign order_live = arb_order_e'(order_rot_i);

    arb_pick #(.NLVL(NLVL), .LVL_W(LVL_W)) u_pick (
        .req     (req),
        .order   (order_live),
        .ptr     (ptr_q),
        .win_vld (win_vld),
        .win_lvl (win_lvl)
    );

    arb_clear #(.NLVL(NLVL), .LVL_W(LVL_W)) u_clear (
        .req   (req),
        .order (order_q),
        .owner (lvl_q),
        .beats (beats)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!busy && win_vld) state_d = ST_GRANT;
            ST_GRANT: if (busy)             state_d = ST_OWNED;
            ST_OWNED: begin
                if (!busy)      state_d = ST_IDLE;
                else if (beats) state_d = ST_CLEAR;
            end
            ST_CLEAR: if (!busy)            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // grant level, rotation pointer and latched ordering
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            ptr_q   <= '0;
            order_q <= ORD_FIXED;
        end else if (state_q == ST_IDLE) begin
            order_q <= order_live;
            if (state_d == ST_GRANT) begin
                lvl_q <= win_lvl;
                if (order_live == ORD_ROTATE) begin
                    ptr_q <= (win_lvl == LVL_W'(NLVL-1)) ? '0 : win_lvl + LVL_W'(1);
                end
            end
        end
    end

    // outputs decoded from registered state
    always_comb begin
        grant_n_o = '1;
        if (state_q == ST_GRANT) grant_n_o[lvl_q] = 1'b0;
        clear_n_o = (state_q != ST_CLEAR);
    end

    // ---------------- assertions ----------------
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~grant_n_o));

    assert_no_grant_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !busy_n_i) |=> (grant_n_o == '1));

    assert_grant_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_n_o != '1 && busy_n_i) |=> $stable(grant_n_o));

    assert_grant_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_n_o != '1 && !busy_n_i) |=> (grant_n_o == '1));

    assert_clear_needs_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear_n_o) |-> $past(state_q == ST_OWNED && !busy_n_i));

    assert_clear_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!clear_n_o && grant_n_o != '1));

    assert_clear_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n_o && busy_n_i) |=> clear_n_o);

    assert_order_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(order_q));

endmodule

// File: tb/sim_bus_arbiter4.sv
module sim_bus_arbiter4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       order_rot = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       busy_n = 1'b1;
    logic [3:0] grant_n;
    logic       clear_n;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    bus_arbiter4 #(.NLVL(4)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .order_rot_i (order_rot),
        .req_n_i     (req_n),
        .busy_n_i    (busy_n),
        .grant_n_o   (grant_n),
        .clear_n_o   (clear_n)
    );

    function automatic logic [3:0] gnt(input int lvl);
        return ~(4'b0001 << lvl);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic rot);
        rst_n = 1'b0; req_n = 4'hF; busy_n = 1'b1; order_rot = rot;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 grants idle", {4'h0, grant_n}, 8'h0F);
        chk("R1 clear idle", {7'h0, clear_n}, 8'h01);
    endtask

    task automatic t_fixed();
        do_reset(1'b0);
        req_n = 4'b0100;                 // levels 3,1,0
        tick();
        chk("R3 highest wins", {4'h0, grant_n}, {4'h0, gnt(3)});
        chk("R2 single grant", 8'($countones(~grant_n)), 8'd1);
        tick();
        chk("R6 grant held", {4'h0, grant_n}, {4'h0, gnt(3)});
        busy_n = 1'b0; req_n = 4'b1100;  // owner drops request
        tick();
        chk("R6 grant removed", {4'h0, grant_n}, 8'h0F);
        tick();
        chk("R8 lower no clear", {7'h0, clear_n}, 8'h01);
        busy_n = 1'b1;
        tick();
        chk("R7 idle gap", {4'h0, grant_n}, 8'h0F);
        tick();
        chk("R3 next highest", {4'h0, grant_n}, {4'h0, gnt(1)});
    endtask

    task automatic t_holdoff();
        do_reset(1'b0);
        busy_n = 1'b0; req_n = 4'b1110;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5 no grant busy", {4'h0, grant_n}, 8'h0F);
        end
        busy_n = 1'b1;
        tick();
        chk("R5 grant after free", {4'h0, grant_n}, {4'h0, gnt(0)});
    endtask

    task automatic t_rwd();
        do_reset(1'b0);
        req_n = 4'b1101;
        tick();
        chk("R7 first grant", {4'h0, grant_n}, {4'h0, gnt(1)});
        busy_n = 1'b0; req_n = 4'hF;
        tick();
        busy_n = 1'b1; req_n = 4'b1101;
        tick();
        chk("R7 gap after release", {4'h0, grant_n}, 8'h0F);
        tick();
        chk("R7 rearbitrated", {4'h0, grant_n}, {4'h0, gnt(1)});
    endtask

    task automatic t_clear_fixed();
        do_reset(1'b0);
        req_n = 4'b1101;
        tick();
        busy_n = 1'b0; req_n = 4'b1110;
        tick(); tick();
        chk("R8 lower level no clear", {7'h0, clear_n}, 8'h01);
        req_n = 4'b1011;
        tick();
        chk("R8 higher level clear", {7'h0, clear_n}, 8'h00);
        tick();
        chk("R9 clear held", {7'h0, clear_n}, 8'h00);
        chk("R9 no grant in clear", {4'h0, grant_n}, 8'h0F);
        busy_n = 1'b1;
        tick();
        chk("R9 clear dropped", {7'h0, clear_n}, 8'h01);
        tick();
        chk("R3 clearing level granted", {4'h0, grant_n}, {4'h0, gnt(2)});
    endtask

    task automatic serve_rr(input int exp_lvl, input string tag);
        tick();
        chk(tag, {4'h0, grant_n}, {4'h0, gnt(exp_lvl)});
        busy_n = 1'b0;
        tick();
        tick();
        chk("R8 rotating clear", {7'h0, clear_n}, 8'h00);
        busy_n = 1'b1;
        tick();
    endtask

    task automatic t_rotate();
        do_reset(1'b1);
        req_n = 4'b0000;
        for (int k = 0; k < 5; k++) serve_rr(k % 4, "R4 rotation order");
        do_reset(1'b1);
        req_n = 4'b1010;                 // levels 2 and 0
        serve_rr(0, "R4 skip from 0");
        serve_rr(2, "R4 skip to 2");
        serve_rr(0, "R4 wrap to 0");
        do_reset(1'b1);
        req_n = 4'b1101;
        tick();
        busy_n = 1'b0;
        tick(); tick();
        chk("R8 own level no clear", {7'h0, clear_n}, 8'h01);
    endtask

    task automatic t_order_latch();
        do_reset(1'b0);
        req_n = 4'b1011;                 // level 2, fixed ordering
        tick();
        chk("R3 fixed grant", {4'h0, grant_n}, {4'h0, gnt(2)});
        busy_n = 1'b0; req_n = 4'hF;
        tick();
        order_rot = 1'b1; req_n = 4'b1110;
        tick(); tick(); tick();
        chk("R10 latched fixed no clear", {7'h0, clear_n}, 8'h01);
        busy_n = 1'b1; req_n = 4'b0110;  // levels 3 and 0
        tick();
        tick();
        chk("R4 R10 pointer kept at 0", {4'h0, grant_n}, {4'h0, gnt(0)});
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_fixed();
        t_holdoff();
        t_rwd();
        t_clear_fixed();
        t_rotate();
        t_order_latch();
        summary();
    end

endmodule